// File: doc/BRIEF.md
# Dual-Convention Host Bus Front End for a Four-Channel UART

This block is the host-facing front end of a four-channel UART register file. One static input picks which of two processor bus styles the block accepts. The first style gives each channel its own active-low chip select and uses separate active-low read and write strobes. The second style uses one shared active-low chip select, takes the channel number from two extra address bits, and has one combined read/write line.

The host strobes are asynchronous to the core. The block passes them through a two-flop synchronizer and detects the edge where a transfer starts. That edge produces a single-cycle read or write enable for the addressed channel. The enable comes with the three-bit register address and, for a write, the captured write data. For a read, the block captures the addressed channel's read data one cycle later and drives the data-bus output enable until the host releases the strobe.

The block also shapes the channels' interrupt requests into the output style of the selected bus convention. The reset pin's polarity follows the mode as well. The channel register logic, the serial logic and the tristate pads are outside this block; the pad enables appear here as plain signals.

Top module: `quad_host_bus_if`

## Requirements
- R1: With `modeIntel`=1, a channel is selected when its own bit of `csN` is 0, with bit 0 for channel A through bit 3 for channel D. A falling `rdN` or falling `wrN` while a channel is selected raises bit i of `regRdEn` or `regWrEn`. This happens on the third rising clock edge after the change.
- R2: With `modeIntel`=0, the falling edge of `csAllN` starts a transfer. The channel comes from `addr[4:3]`, with 00=A, 01=B, 10=C and 11=D. `wrN` acts as read/write, with 1 meaning read and 0 meaning write. `rdN` has no effect.
- R3: In both modes, `regAddr` equals `addr[2:0]` while the enable is high. On a write, `regWrData` equals the `busDataIn` value held during the strobe.
- R4: Each strobe assertion yields exactly one cycle of enable, however long the strobe is held.
- R5: One cycle after a read enable, `busDataOe` goes to 1 and `busDataOut` holds the addressed channel's byte from `chanRdData` (channel i in bits 8i+7:8i). Both stay stable until the strobe is released. `busDataOe` then falls on the third rising edge after the release.
- R6: When no channel is selected, no enable fires and `busDataOe` stays 0. `busDataOut` reads 8'h00 whenever `busDataOe` is 0.
- R7: With `modeIntel`=1, `intOut` follows `chanIrq` and `irqN` stays 1. Bit i of `intOe` is 1 when either `intSel` is 1 or bit i of `chanOutEn` is 1.
- R8: With `modeIntel`=0, `irqN` is 0 exactly when any bit of `chanIrq` is 1. In this mode `intOe` and `intOut` are all 0.
- R9: Reset is active when `rstPin`=1 in Intel mode and when `rstPin`=0 in Motorola mode. `chanRst` shows the active reset. While reset is active, the enables and `busDataOe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstPin | input | 1 | Reset pin; its polarity depends on the mode |
| modeIntel | input | 1 | 1 selects the Intel-style bus, 0 selects the Motorola-style bus |
| csN | input | 4 | Per-channel active-low chip selects (Intel mode) |
| csAllN | input | 1 | Shared active-low chip select (Motorola mode) |
| addr | input | 5 | Register address in [2:0], channel number in [4:3] (Motorola mode) |
| rdN | input | 1 | Active-low read strobe (Intel mode) |
| wrN | input | 1 | Active-low write strobe, or read/write line in Motorola mode |
| busDataIn | input | 8 | Host write data |
| busDataOut | output | 8 | Host read data |
| busDataOe | output | 1 | Data-bus output enable |
| chanRst | output | 1 | Active-high reset to the channels |
| regAddr | output | 3 | Register address to the channels |
| regWrData | output | 8 | Write data to the channels |
| regWrEn | output | 4 | Per-channel write enable pulses |
| regRdEn | output | 4 | Per-channel read enable pulses |
| chanRdData | input | 32 | Read data from each channel for `regAddr` |
| chanIrq | input | 4 | Per-channel interrupt requests |
| chanOutEn | input | 4 | Per-channel interrupt output enable bits from the channels' control registers |
| intSel | input | 1 | Forces the Intel-mode interrupt outputs to be enabled |
| intOut | output | 4 | Intel-mode active-high interrupt outputs |
| intOe | output | 4 | Tristate enables for `intOut` |
| irqN | output | 1 | Motorola-mode combined active-low request |

## Verification
The assertions assume that the address, the write data, the chip selects and the read/write line stay stable for the whole time a strobe is held. They also assume that `modeIntel` changes only while reset is active. In both modes, the first edge-detect stage samples the address and data without synchronizing them, so the block's correctness depends on these assumptions.

The stimulus follows them. For a Motorola-style transfer, it sets the address, the data and the read/write line one cycle before pulling the chip select low, and it restores the read/write line only after the select has risen. It changes mode only while holding the reset pin at the new mode's active level. It releases every strobe before it lets reset go, so that no transfer starts against a freshly cleared synchronizer.

// File: rtl/qhb_pkg.sv
package qhb_pkg;
  localparam int CH_NUM = 4;
  localparam int CH_AW  = $clog2(CH_NUM);

  typedef struct packed {
    logic              rdPulse;
    logic              wrPulse;
    logic              oeClr;
    logic [CH_NUM-1:0] chanSel;
  } busStrobe_t;
endpackage

// File: rtl/qhb_ctrl.sv
module qhb_ctrl
  import qhb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstAct,
  input  logic              modeIntel,
  input  logic [CH_NUM-1:0] csN,
  input  logic              csAllN,
  input  logic [CH_AW-1:0]  chanAddr,
  input  logic              rdN,
  input  logic              wrN,
  output busStrobe_t        strobe
);
  localparam int RAW_W = CH_NUM + 3;

  logic [RAW_W-1:0] rawBus;
  logic [RAW_W-1:0] syncQ [SYNC_STAGES];
  logic [RAW_W-1:0] syncBus;

  assign rawBus = {csAllN, csN, rdN, wrN};

  // Two-flop (or deeper) synchronizer; idle level is all ones.
  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '1;
    end else begin
      syncQ[0] <= rawBus;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  assign syncBus = syncQ[SYNC_STAGES-1];

  logic              wrS, rdS, csAllS;
  logic [CH_NUM-1:0] csS;
  logic [CH_NUM-1:0] selOneHot;
  logic              anySel, rdAct, wrAct;
  logic              rdPrev, wrPrev;

  assign {csAllS, csS, rdS, wrS} = syncBus;

  always_comb begin
    if (modeIntel) selOneHot = ~csS;
    else           selOneHot = csAllS ? '0 : (CH_NUM'(1) << chanAddr);
  end

  assign anySel = |selOneHot;
  // Intel: separate strobes. Motorola: wrN is R/W (1 = read), rdN unused.
  assign rdAct  = anySel & (modeIntel ? ~rdS : wrS);
  assign wrAct  = anySel & ~wrS;

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= rdAct;
      wrPrev <= wrAct;
    end
  end

  assign strobe.rdPulse = rdAct & ~rdPrev;
  assign strobe.wrPulse = wrAct & ~wrPrev;
  assign strobe.oeClr   = ~rdAct;
  assign strobe.chanSel = selOneHot;
endmodule

// File: rtl/qhb_datapath.sv
module qhb_datapath
  import qhb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 3
) (
  input  logic                     clk,
  input  logic                     rstAct,
  input  logic                     modeIntel,
  input  busStrobe_t               strobe,
  input  logic [REG_AW-1:0]        regSel,
  input  logic [DATA_W-1:0]        busDataIn,
  input  logic [CH_NUM*DATA_W-1:0] chanRdData,
  input  logic [CH_NUM-1:0]        chanIrq,
  input  logic [CH_NUM-1:0]        chanOutEn,
  input  logic                     intSel,
  output logic [REG_AW-1:0]        regAddr,
  output logic [DATA_W-1:0]        regWrData,
  output logic [CH_NUM-1:0]        regWrEn,
  output logic [CH_NUM-1:0]        regRdEn,
  output logic [DATA_W-1:0]        busDataOut,
  output logic                     busDataOe,
  output logic [CH_NUM-1:0]        intOut,
  output logic [CH_NUM-1:0]        intOe,
  output logic                     irqN
);
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < CH_NUM; i++)
      if (regRdEn[i]) rdMux = rdMux | chanRdData[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or posedge rstAct) begin
    if (rstAct) begin
      regAddr    <= '0;
      regWrData  <= '0;
      regWrEn    <= '0;
      regRdEn    <= '0;
      busDataOut <= '0;
      busDataOe  <= 1'b0;
    end else begin
      regWrEn <= strobe.wrPulse ? strobe.chanSel : '0;
      regRdEn <= strobe.rdPulse ? strobe.chanSel : '0;
      if (strobe.wrPulse || strobe.rdPulse) regAddr <= regSel;
      if (strobe.wrPulse) regWrData <= busDataIn;
      if (strobe.oeClr) begin
        busDataOe  <= 1'b0;
        busDataOut <= '0;
      end else if (|regRdEn) begin
        busDataOe  <= 1'b1;
        busDataOut <= rdMux;
      end
    end
  end

  // Interrupt output shaping per bus convention.
  generate
    for (genvar g = 0; g < CH_NUM; g++) begin : g_int
      assign intOut[g] = modeIntel & chanIrq[g];
      assign intOe[g]  = modeIntel & (intSel | chanOutEn[g]);
    end
  endgenerate

  assign irqN = modeIntel | ~(|chanIrq);
endmodule

// File: rtl/quad_host_bus_if.sv
module quad_host_bus_if
  import qhb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstPin,
  input  logic                     modeIntel,
  input  logic [CH_NUM-1:0]        csN,
  input  logic                     csAllN,
  input  logic [REG_AW+CH_AW-1:0]  addr,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic [DATA_W-1:0]        busDataIn,
  output logic [DATA_W-1:0]        busDataOut,
  output logic                     busDataOe,
  output logic                     chanRst,
  output logic [REG_AW-1:0]        regAddr,
  output logic [DATA_W-1:0]        regWrData,
  output logic [CH_NUM-1:0]        regWrEn,
  output logic [CH_NUM-1:0]        regRdEn,
  input  logic [CH_NUM*DATA_W-1:0] chanRdData,
  input  logic [CH_NUM-1:0]        chanIrq,
  input  logic [CH_NUM-1:0]        chanOutEn,
  input  logic                     intSel,
  output logic [CH_NUM-1:0]        intOut,
  output logic [CH_NUM-1:0]        intOe,
  output logic                     irqN
);
  logic       rstAct;
  busStrobe_t strobe;

  assign rstAct  = modeIntel ? rstPin : ~rstPin;
  assign chanRst = rstAct;

  qhb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstAct   (rstAct),
    .modeIntel(modeIntel),
    .csN      (csN),
    .csAllN   (csAllN),
    .chanAddr (addr[REG_AW +: CH_AW]),
    .rdN      (rdN),
    .wrN      (wrN),
    .strobe   (strobe)
  );

  qhb_datapath #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_dp (
    .clk       (clk),
    .rstAct    (rstAct),
    .modeIntel (modeIntel),
    .strobe    (strobe),
    .regSel    (addr[REG_AW-1:0]),
    .busDataIn (busDataIn),
    .chanRdData(chanRdData),
    .chanIrq   (chanIrq),
    .chanOutEn (chanOutEn),
    .intSel    (intSel),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .intOut    (intOut),
    .intOe     (intOe),
    .irqN      (irqN)
  );
endmodule

// File: rtl/qhb_checker.sv
module qhb_checker #(
  parameter int DATA_W = 8,
  parameter int CH_N   = 4
) (
  input logic              clk,
  input logic              chanRst,
  input logic              modeIntel,
  input logic [CH_N-1:0]   regWrEn,
  input logic [CH_N-1:0]   regRdEn,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataOe
);
  a_r4_wr_single_pulse: assert property (@(posedge clk) disable iff (chanRst)
    (regWrEn != '0) |=> (regWrEn == '0));

  a_r4_rd_single_pulse: assert property (@(posedge clk) disable iff (chanRst)
    (regRdEn != '0) |=> (regRdEn == '0));

  a_r5_oe_after_read: assert property (@(posedge clk) disable iff (chanRst)
    (regRdEn != '0) |=> busDataOe);

  a_r5_data_stable: assert property (@(posedge clk) disable iff (chanRst)
    (busDataOe && $past(busDataOe)) |-> $stable(busDataOut));

  a_r6_zero_when_idle: assert property (@(posedge clk) disable iff (chanRst)
    !busDataOe |-> (busDataOut == '0));

  a_r2_single_channel: assert property (@(posedge clk) disable iff (chanRst)
    !modeIntel |-> $onehot0(regWrEn | regRdEn));

  always @(posedge clk) begin
    if (chanRst === 1'b1) begin
      a_r9_quiet_in_reset: assert (regWrEn == '0 && regRdEn == '0 && !busDataOe);
    end
  end
endmodule

bind quad_host_bus_if qhb_checker #(.DATA_W(DATA_W), .CH_N(qhb_pkg::CH_NUM)) u_chk (
  .clk       (clk),
  .chanRst   (chanRst),
  .modeIntel (modeIntel),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .busDataOut(busDataOut),
  .busDataOe (busDataOe)
);

// File: tb/quad_host_bus_if_bench.sv
`timescale 1ns/1ps
module quad_host_bus_if_bench;
  logic        clk = 1'b0;
  logic        rstPin;
  logic        modeIntel;
  logic [3:0]  csN;
  logic        csAllN;
  logic [4:0]  addr;
  logic        rdN, wrN;
  logic [7:0]  busDataIn;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic        chanRst;
  logic [2:0]  regAddr;
  logic [7:0]  regWrData;
  logic [3:0]  regWrEn, regRdEn;
  logic [31:0] chanRdData;
  logic [3:0]  chanIrq, chanOutEn;
  logic        intSel;
  logic [3:0]  intOut, intOe;
  logic        irqN;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  quad_host_bus_if u_quad_host_bus_if (
    .clk(clk), .rstPin(rstPin), .modeIntel(modeIntel), .csN(csN), .csAllN(csAllN),
    .addr(addr), .rdN(rdN), .wrN(wrN), .busDataIn(busDataIn), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .chanRst(chanRst), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .chanRdData(chanRdData), .chanIrq(chanIrq),
    .chanOutEn(chanOutEn), .intSel(intSel), .intOut(intOut), .intOe(intOe), .irqN(irqN)
  );

  function automatic logic [7:0] chanByte(int ch, logic [2:0] a);
    return 8'((ch + 1) * 16 + int'(a));
  endfunction

  // Channel models: channel i returns 0x10*(i+1) + register address.
  always_comb begin
    for (int i = 0; i < 4; i++) chanRdData[i*8 +: 8] = chanByte(i, regAddr);
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleBus();
    csN = 4'hF; csAllN = 1'b1; rdN = 1'b1; wrN = 1'b1;
  endtask

  task automatic doReset(bit intelMode);
    @(negedge clk);
    modeIntel = intelMode;
    idleBus();
    rstPin = intelMode ? 1'b1 : 1'b0;
    cyc(3);
    rstPin = ~rstPin;
    cyc(2);
  endtask

  typedef struct packed {
    logic       modeI;
    logic [3:0] csSel;
    logic       csAll;
    logic [4:0] a;
    logic       isRd;
    logic [7:0] d;
    logic [3:0] expCh;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'b1110, 1'b1, 5'b00101, 1'b0, 8'hA5, 4'b0001},
    '{1'b1, 4'b1101, 1'b1, 5'b00011, 1'b1, 8'h00, 4'b0010},
    '{1'b1, 4'b1011, 1'b1, 5'b00111, 1'b0, 8'h3C, 4'b0100},
    '{1'b1, 4'b0111, 1'b1, 5'b00000, 1'b1, 8'h00, 4'b1000},
    '{1'b1, 4'b1111, 1'b1, 5'b00010, 1'b0, 8'h77, 4'b0000},
    '{1'b1, 4'b1111, 1'b1, 5'b00010, 1'b1, 8'h00, 4'b0000},
    '{1'b0, 4'b1111, 1'b0, 5'b00001, 1'b0, 8'h5A, 4'b0001},
    '{1'b0, 4'b1111, 1'b0, 5'b01110, 1'b1, 8'h00, 4'b0010},
    '{1'b0, 4'b1111, 1'b0, 5'b10100, 1'b0, 8'hC3, 4'b0100},
    '{1'b0, 4'b1111, 1'b0, 5'b11010, 1'b1, 8'h00, 4'b1000},
    '{1'b0, 4'b1111, 1'b1, 5'b11000, 1'b1, 8'h00, 4'b0000},
    '{1'b0, 4'b1111, 1'b1, 5'b11000, 1'b0, 8'h99, 4'b0000}
  };

  task automatic runVec(vec_t v);
    int ch;
    logic [7:0] expData;
    ch = 0;
    for (int i = 0; i < 4; i++) if (v.expCh[i]) ch = i;
    expData = (v.isRd && v.expCh != 0) ? chanByte(ch, v.a[2:0]) : 8'h00;
    // Launch the transfer at a falling edge.
    if (v.modeI) begin
      csN = v.csSel; addr = v.a; busDataIn = v.d;
      if (v.isRd) rdN = 1'b0; else wrN = 1'b0;
    end else begin
      addr = v.a; busDataIn = v.d; wrN = v.isRd; rdN = 1'b1;
      @(negedge clk);
      csAllN = v.csAll;
    end
    cyc(3);
    check(regWrEn == (v.isRd ? 4'b0 : v.expCh), "R1/R2 write enable", 32'(regWrEn), 32'(v.isRd ? 4'b0 : v.expCh));
    check(regRdEn == (v.isRd ? v.expCh : 4'b0), "R1/R2 read enable", 32'(regRdEn), 32'(v.isRd ? v.expCh : 4'b0));
    if (v.expCh != 0) begin
      check(regAddr == v.a[2:0], "R3 register address", 32'(regAddr), 32'(v.a[2:0]));
      if (!v.isRd) check(regWrData == v.d, "R3 write data", 32'(regWrData), 32'(v.d));
    end
    cyc(1);
    check(regWrEn == 0 && regRdEn == 0, "R4 enable lasts one cycle", 32'({regWrEn, regRdEn}), 32'h0);
    check(busDataOe == (v.isRd && v.expCh != 0), "R5/R6 output enable", 32'(busDataOe), 32'(v.isRd && v.expCh != 0));
    check(busDataOut == expData, "R5/R6 read data", 32'(busDataOut), 32'(expData));
    cyc(5);
    check(regWrEn == 0 && regRdEn == 0, "R4 no repeat while held", 32'({regWrEn, regRdEn}), 32'h0);
    check(busDataOut == expData, "R5 data held", 32'(busDataOut), 32'(expData));
    // Release.
    if (v.modeI) idleBus();
    else begin
      csAllN = 1'b1;
      @(negedge clk);
      wrN = 1'b1;
    end
    if (v.modeI) begin
      cyc(2);
      check(busDataOe == (v.isRd && v.expCh != 0), "R5 enable until release seen", 32'(busDataOe), 32'(v.isRd && v.expCh != 0));
      cyc(1);
    end else cyc(2);
    check(!busDataOe && busDataOut == 8'h00, "R5/R6 released bus", 32'({busDataOe, busDataOut}), 32'h0);
    check(regWrEn == 0 && regRdEn == 0, "R4 no pulse on release", 32'({regWrEn, regRdEn}), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modeIntel = 1'b1; rstPin = 1'b1; idleBus();
    addr = '0; busDataIn = '0; chanIrq = '0; chanOutEn = '0; intSel = 1'b0;
    cyc(3);
    // R9: Intel reset active high.
    check(chanRst == 1'b1, "R9 intel reset active", 32'(chanRst), 32'h1);
    check(regWrEn == 0 && regRdEn == 0 && !busDataOe, "R9 quiet in reset", 32'({regWrEn, regRdEn, busDataOe}), 32'h0);
    rstPin = 1'b0;
    cyc(2);
    check(chanRst == 1'b0, "R9 intel reset released", 32'(chanRst), 32'h0);

    begin
      bit curMode = 1'b1;
      for (int i = 0; i < NV; i++) begin
        if (VECS[i].modeI != curMode) begin
          doReset(VECS[i].modeI);
          curMode = VECS[i].modeI;
        end
        runVec(VECS[i]);
      end
    end

    // R2: in Motorola mode rdN pulses without chip select or with a write do nothing extra.
    doReset(1'b0);
    rdN = 1'b0;
    cyc(5);
    check(regWrEn == 0 && regRdEn == 0 && !busDataOe, "R2 rdN ignored", 32'({regWrEn, regRdEn, busDataOe}), 32'h0);
    rdN = 1'b1;
    addr = 5'b01001; wrN = 1'b0; busDataIn = 8'h6E;
    @(negedge clk);
    csAllN = 1'b0; rdN = 1'b0;
    cyc(3);
    check(regWrEn == 4'b0010 && regRdEn == 0, "R2 rdN low does not make a read", 32'({regWrEn, regRdEn}), 32'h20);
    idleBus();
    cyc(4);

    // R8: Motorola interrupt shaping.
    chanIrq = 4'b0000; chanOutEn = 4'hF; intSel = 1'b1;
    cyc(1);
    check(irqN == 1'b1 && intOe == 0 && intOut == 0, "R8 no request", 32'({irqN, intOe, intOut}), 32'h100);
    chanIrq = 4'b0100;
    cyc(1);
    check(irqN == 1'b0 && intOe == 0 && intOut == 0, "R8 request low", 32'({irqN, intOe, intOut}), 32'h000);

    // R9: Motorola reset is active low.
    rstPin = 1'b1;
    cyc(1);
    check(chanRst == 1'b0, "R9 motorola pin high is not reset", 32'(chanRst), 32'h0);
    rstPin = 1'b0;
    cyc(1);
    check(chanRst == 1'b1, "R9 motorola pin low is reset", 32'(chanRst), 32'h1);
    rstPin = 1'b1;
    cyc(1);

    // R7: Intel interrupt shaping.
    doReset(1'b1);
    chanIrq = 4'b1010; chanOutEn = 4'b0011; intSel = 1'b0;
    cyc(1);
    check(intOut == 4'b1010, "R7 intOut follows", 32'(intOut), 32'ha);
    check(intOe == 4'b0011, "R7 enable from channel bit", 32'(intOe), 32'h3);
    check(irqN == 1'b1, "R7 irqN idle", 32'(irqN), 32'h1);
    intSel = 1'b1;
    cyc(1);
    check(intOe == 4'b1111, "R7 intSel forces enable", 32'(intOe), 32'hf);

    // R9: reset during an open read clears the output enable.
    csN = 4'b1011; addr = 5'b00110; rdN = 1'b0;
    cyc(4);
    check(busDataOe == 1'b1 && busDataOut == chanByte(2, 3'd6), "R5 read before reset", 32'({busDataOe, busDataOut}), 32'({1'b1, chanByte(2, 3'd6)}));
    rstPin = 1'b1;
    cyc(1);
    check(!busDataOe && busDataOut == 0, "R9 reset clears read", 32'({busDataOe, busDataOut}), 32'h0);
    idleBus();
    cyc(3);
    rstPin = 1'b0;
    cyc(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule